// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses from a bank of eight register sets. Each set holds an index pointer, a modify step, a buffer base and a buffer length. An access request names one index register and a modifier, which is either one of the modify registers or an immediate. The request also says when the modifier is applied. Before the access (premodify), the block emits index plus modifier and leaves the pointer unchanged. After the access (postmodify), the block emits the pointer as it stands and then advances it, wrapping it back into the buffer when the length is nonzero.

One register set, set 7 by default, watches for wrap-around. When a postmodify access on that set steps past either end of its buffer, the block raises a one-cycle interrupt pulse and latches a sticky status bit, which stays set until it is cleared. Software loads and reads the registers through a simple write/read port. Loading a base register also loads the matching index register.

Top module: `cbag_top`

## Requirements
- R1: A premodify access (acc_post=0) outputs index+modifier, truncated to the address width, and leaves the index register unchanged; the base and length registers play no part in it.
- R2: A postmodify access (acc_post=1) outputs the current index value and writes the updated index back at the same clock edge.
- R3: With a nonnegative modifier M and a nonzero length L, the postmodify update is I+M−L when I+M ≥ B+L, and I+M otherwise (base 0, length 11, step 4 visits 0,4,8,1,5,9,2,6,10,3,7 and then repeats).
- R4: With a negative modifier (most significant bit set, two's complement) and a nonzero length, the update is I+M+L when I+M < B, and I+M otherwise.
- R5: A length of 0 disables wrapping, so the postmodify update is plain I+M.
- R6: Register kinds on cfg_kind are 0 = index, 1 = modify, 2 = base, 3 = length. A base write also loads the same-numbered index register, and an index write leaves the base unchanged. cfg_rdata shows, in the same cycle, the register that cfg_kind and cfg_sel select.
- R7: A postmodify access on set OVF_SET (default 7) whose sum satisfies I+M ≥ B+L (M ≥ 0) or I+M < B (M < 0) raises ovf_irq for exactly one cycle. Accesses on any other set, and all premodify accesses, never raise it.
- R8: The overflow test of R7 is applied even when the length is 0.
- R9: ovf_sticky sets together with ovf_irq and stays set until an ovf_clr pulse arrives in a cycle with no new overflow. When a new overflow and ovf_clr coincide, the bit stays set.
- R10: The modifier comes from acc_imm when acc_use_imm=1, and otherwise from modify register acc_msel. Any modify register may serve any index register.
- R11: addr_valid and addr_out are registered. They reflect a request one clock edge after it is presented. addr_valid is 0 after a cycle with no request, and addr_out then holds its value.
- R12: After reset, all registers read 0 and addr_valid, addr_out, ovf_irq and ovf_sticky are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | Register kind for write and read |
| cfg_sel | input | 3 | Register set number for write and read |
| cfg_wdata | input | AW | Write data |
| cfg_rdata | output | AW | Read data of selected register |
| acc_valid | input | 1 | Access request |
| acc_post | input | 1 | 1 = postmodify, 0 = premodify |
| acc_isel | input | 3 | Index register number |
| acc_use_imm | input | 1 | 1 = immediate modifier |
| acc_msel | input | 3 | Modify register number |
| acc_imm | input | AW | Immediate modifier, two's complement |
| ovf_clr | input | 1 | Clear strobe for ovf_sticky |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | AW | Generated address |
| ovf_irq | output | 1 | Wrap interrupt pulse for the watched set |
| ovf_sticky | output | 1 | Latched wrap status |

## Verification
The long directed walk with base 0, length 11 and step 4 shows whether the wrap subtracts the length at exactly the end boundary. Stepping backwards below the base checks the add-back direction. Running the same wrap on the watched set and on an ordinary set separates the interrupt decode from the wrap arithmetic, and a zero-length access on the watched set shows that the overflow test runs independently of wrapping. Random buffers with random bases, lengths, start points and signed steps smaller than the length, mixed with random premodify accesses and random clear strobes, check that premodify never disturbs a pointer and that set and clear collide correctly.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
    typedef enum logic [1:0] {
        KIND_IDX  = 2'd0,
        KIND_MOD  = 2'd1,
        KIND_BASE = 2'd2,
        KIND_LEN  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/cbag_regfile.sv
module cbag_regfile
    import cbag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NSET = 8,
    parameter int SW   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  reg_kind_e                 cfg_kind,
    input  logic [SW-1:0]             cfg_sel,
    input  logic [AW-1:0]             cfg_wdata,
    input  logic                      upd_en,
    input  logic [SW-1:0]             upd_sel,
    input  logic [AW-1:0]             upd_val,
    output logic [NSET-1:0][AW-1:0]   idx_all,
    output logic [NSET-1:0][AW-1:0]   mod_all,
    output logic [NSET-1:0][AW-1:0]   base_all,
    output logic [NSET-1:0][AW-1:0]   len_all
);
    typedef struct packed {
        logic [NSET-1:0][AW-1:0] idx;
        logic [NSET-1:0][AW-1:0] mods;
        logic [NSET-1:0][AW-1:0] base;
        logic [NSET-1:0][AW-1:0] len;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // pointer writeback from a postmodify access
        if (upd_en) begin
            bank_d.idx[upd_sel] = upd_val;
        end
        // a software write to the same register wins over the writeback
        if (cfg_we) begin
            unique case (cfg_kind)
                KIND_IDX:  bank_d.idx[cfg_sel]  = cfg_wdata;
                KIND_MOD:  bank_d.mods[cfg_sel] = cfg_wdata;
                KIND_BASE: begin
                    bank_d.base[cfg_sel] = cfg_wdata;
                    bank_d.idx[cfg_sel]  = cfg_wdata;
                end
                KIND_LEN:  bank_d.len[cfg_sel]  = cfg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign idx_all  = bank_q.idx;
    assign mod_all  = bank_q.mods;
    assign base_all = bank_q.base;
    assign len_all  = bank_q.len;
endmodule

// File: rtl/cbag_step.sv
module cbag_step #(
    parameter int AW = 32
) (
    input  logic          post,
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] new_idx,
    output logic          bound_hit
);
    // two guard bits: one for the unsigned carry, one for the sign
    localparam int EW = AW + 2;

    logic signed [EW-1:0] idx_x, step_x, base_x, len_x;
    logic signed [EW-1:0] sum_x, top_x, fold_x, pick_x;
    logic                 step_neg;
    logic                 len_zero;

    always_comb begin
        step_neg = step[AW-1];
        len_zero = (len == '0);
        idx_x    = {2'b00, idx};
        base_x   = {2'b00, base};
        len_x    = {2'b00, len};
        step_x   = {{2{step[AW-1]}}, step};
        sum_x    = idx_x + step_x;
        top_x    = base_x + len_x;
        if (step_neg) begin
            bound_hit = (sum_x < base_x);
            fold_x    = sum_x + len_x;
        end else begin
            bound_hit = (sum_x >= top_x);
            fold_x    = sum_x - len_x;
        end
        pick_x  = (bound_hit && !len_zero) ? fold_x : sum_x;
        new_idx = pick_x[AW-1:0];
        addr    = post ? idx : sum_x[AW-1:0];
    end
endmodule

// File: rtl/cbag_top.sv
module cbag_top
    import cbag_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NSET    = 8,
    parameter int OVF_SET = 7,
    localparam int SW     = $clog2(NSET)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_kind,
    input  logic [SW-1:0] cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          acc_valid,
    input  logic          acc_post,
    input  logic [SW-1:0] acc_isel,
    input  logic          acc_use_imm,
    input  logic [SW-1:0] acc_msel,
    input  logic [AW-1:0] acc_imm,
    input  logic          ovf_clr,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out,
    output logic          ovf_irq,
    output logic          ovf_sticky
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          irq;
        logic          sticky;
    } out_t;

    reg_kind_e               kind;
    logic [NSET-1:0][AW-1:0] idx_all, mod_all, base_all, len_all;
    logic [AW-1:0]           cur_idx, cur_step, cur_base, cur_len;
    logic [AW-1:0]           gen_addr, gen_idx;
    logic                    gen_hit;
    logic                    post_go, ovf_event;
    out_t                    out_d, out_q;

    assign kind = reg_kind_e'(cfg_kind);

    cbag_regfile #(.AW(AW), .NSET(NSET), .SW(SW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_kind (kind),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .upd_en   (post_go),
        .upd_sel  (acc_isel),
        .upd_val  (gen_idx),
        .idx_all  (idx_all),
        .mod_all  (mod_all),
        .base_all (base_all),
        .len_all  (len_all)
    );

    always_comb begin
        cur_idx  = idx_all[acc_isel];
        cur_base = base_all[acc_isel];
        cur_len  = len_all[acc_isel];
        cur_step = acc_use_imm ? acc_imm : mod_all[acc_msel];
    end

    cbag_step #(.AW(AW)) u_step (
        .post     (acc_post),
        .idx      (cur_idx),
        .step     (cur_step),
        .base     (cur_base),
        .len      (cur_len),
        .addr     (gen_addr),
        .new_idx  (gen_idx),
        .bound_hit(gen_hit)
    );

    always_comb begin
        unique case (kind)
            KIND_IDX:  cfg_rdata = idx_all[cfg_sel];
            KIND_MOD:  cfg_rdata = mod_all[cfg_sel];
            KIND_BASE: cfg_rdata = base_all[cfg_sel];
            default:   cfg_rdata = len_all[cfg_sel];
        endcase
    end

    always_comb begin
        post_go   = acc_valid && acc_post;
        ovf_event = post_go && (32'(acc_isel) == OVF_SET) && gen_hit;
        out_d        = out_q;
        out_d.vld    = acc_valid;
        out_d.irq    = ovf_event;
        out_d.sticky = ovf_event || (out_q.sticky && !ovf_clr);
        if (acc_valid) begin
            out_d.addr = gen_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_valid = out_q.vld;
    assign addr_out   = out_q.addr;
    assign ovf_irq    = out_q.irq;
    assign ovf_sticky = out_q.sticky;
endmodule

// File: rtl/cbag_checks.sv
module cbag_checks #(
    parameter int AW      = 32,
    parameter int NSET    = 8,
    parameter int SW      = 3,
    parameter int OVF_SET = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [1:0]              cfg_kind,
    input logic [SW-1:0]           cfg_sel,
    input logic [AW-1:0]           cfg_wdata,
    input logic                    acc_valid,
    input logic                    acc_post,
    input logic [SW-1:0]           acc_isel,
    input logic                    ovf_clr,
    input logic                    addr_valid,
    input logic [AW-1:0]           addr_out,
    input logic                    ovf_irq,
    input logic                    ovf_sticky,
    input logic [NSET-1:0][AW-1:0] idx_all
);
    logic [AW-1:0] sel_idx;
    logic          watched_post;
    assign sel_idx      = idx_all[acc_isel];
    assign watched_post = acc_valid && acc_post && (32'(acc_isel) == OVF_SET);

    AST_PRE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_post && !cfg_we) |=> $stable(idx_all)); // R1

    AST_POST_EMITS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_post) |=> (addr_out == $past(sel_idx))); // R2

    AST_BASE_LOADS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == 2'd2) |=> (idx_all[$past(cfg_sel)] == $past(cfg_wdata))); // R6

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> $past(watched_post)); // R7

    AST_IRQ_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_sticky); // R9

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !ovf_clr) |=> ovf_sticky); // R9

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> addr_valid); // R11

    AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!addr_valid && $stable(addr_out))); // R11
endmodule

bind cbag_top cbag_checks #(.AW(AW), .NSET(NSET), .SW(SW), .OVF_SET(OVF_SET)) u_checks (.*);

// File: tb/cbag_top_test.sv
module cbag_top_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = 2'd0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          acc_valid = 1'b0;
    logic          acc_post = 1'b0;
    logic [2:0]    acc_isel = 3'd0;
    logic          acc_use_imm = 1'b0;
    logic [2:0]    acc_msel = 3'd0;
    logic [AW-1:0] acc_imm = '0;
    logic          ovf_clr = 1'b0;
    logic          addr_valid;
    logic [AW-1:0] addr_out;
    logic          ovf_irq;
    logic          ovf_sticky;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    logic [AW-1:0] m_idx [8];
    logic [AW-1:0] m_mod [8];
    logic [AW-1:0] m_base [8];
    logic [AW-1:0] m_len [8];
    bit            m_sticky;

    always #10 clk = ~clk;

    cbag_top uut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic void expect_step(input logic [31:0] i, m, b, l, input bit post,
                                        output logic [31:0] addr, nidx, output bit hit);
        longint s, lo, hi, r;
        s  = longint'(i) + longint'($signed(m));
        lo = longint'(b);
        hi = longint'(b) + longint'(l);
        hit = m[31] ? (s < lo) : (s >= hi);
        r = s;
        if (hit && l != 0) r = m[31] ? s + longint'(l) : s - longint'(l);
        nidx = r[31:0];
        addr = post ? i : s[31:0];
    endfunction

    task automatic wr(input logic [1:0] k, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_sel = s; cfg_wdata = d;
        @(posedge clk);
        #2 cfg_we = 1'b0;
        case (k)
            2'd0: m_idx[s] = d;
            2'd1: m_mod[s] = d;
            2'd2: begin m_base[s] = d; m_idx[s] = d; end
            default: m_len[s] = d;
        endcase
    endtask

    task automatic rd(input string req, input logic [1:0] k, input logic [2:0] s,
                      input logic [31:0] exp);
        cfg_kind = k; cfg_sel = s;
        #1 chk(req, "readback", 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic acc(input string req, input bit post, input logic [2:0] isel,
                       input bit use_imm, input logic [2:0] msel, input logic [31:0] imm,
                       input bit clr);
        logic [31:0] m, ea, ni;
        bit hit, irq;
        m = use_imm ? imm : m_mod[msel];
        expect_step(m_idx[isel], m, m_base[isel], m_len[isel], post, ea, ni, hit);
        irq = post && isel == 3'd7 && hit;
        @(negedge clk);
        acc_valid = 1'b1; acc_post = post; acc_isel = isel;
        acc_use_imm = use_imm; acc_msel = msel; acc_imm = imm; ovf_clr = clr;
        @(posedge clk);
        #2 acc_valid = 1'b0; ovf_clr = 1'b0;
        if (post) m_idx[isel] = ni;
        m_sticky = irq || (m_sticky && !clr);
        chk(req, "addr_valid", 64'(addr_valid), 64'd1);
        chk(req, "addr_out", 64'(addr_out), 64'(ea));
        chk(req, "ovf_irq", 64'(ovf_irq), 64'(irq));
        chk(req, "ovf_sticky", 64'(ovf_sticky), 64'(m_sticky));
    endtask

    task automatic idle(input string req, input bit clr);
        logic [31:0] held;
        held = addr_out;
        @(negedge clk);
        ovf_clr = clr;
        @(posedge clk);
        #2 ovf_clr = 1'b0;
        m_sticky = m_sticky && !clr;
        chk(req, "idle addr_valid", 64'(addr_valid), 64'd0);
        chk(req, "idle addr_out", 64'(addr_out), 64'(held));
        chk(req, "idle ovf_irq", 64'(ovf_irq), 64'd0);
        chk(req, "idle ovf_sticky", 64'(ovf_sticky), 64'(m_sticky));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seq [11];
        seq = '{32'd0, 32'd4, 32'd8, 32'd1, 32'd5, 32'd9, 32'd2, 32'd6, 32'd10, 32'd3, 32'd7};
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) begin
            m_idx[k] = '0; m_mod[k] = '0; m_base[k] = '0; m_len[k] = '0;
        end
        m_sticky = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R12: reset state
        chk("R12", "addr_valid", 64'(addr_valid), 64'd0);
        chk("R12", "addr_out", 64'(addr_out), 64'd0);
        chk("R12", "ovf_irq", 64'(ovf_irq), 64'd0);
        chk("R12", "ovf_sticky", 64'(ovf_sticky), 64'd0);
        rd("R12", 2'd0, 3'd3, 32'd0);
        rd("R12", 2'd3, 3'd7, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: base write loads index, index write keeps base
        wr(2'd2, 3'd2, 32'h100);
        rd("R6", 2'd0, 3'd2, 32'h100);
        wr(2'd0, 3'd2, 32'h105);
        rd("R6", 2'd2, 3'd2, 32'h100);
        rd("R6", 2'd0, 3'd2, 32'h105);

        // R3 / R2 / R10: base 0, length 11, step 4 via modify register 5
        wr(2'd2, 3'd2, 32'd0);
        wr(2'd3, 3'd2, 32'd11);
        wr(2'd1, 3'd5, 32'd4);
        for (int p = 0; p < 22; p++) begin
            acc("R3", 1'b1, 3'd2, 1'b0, 3'd5, 32'd0, 1'b0);
            chk("R3", "sequence", 64'(addr_out), 64'(seq[p % 11]));
        end
        rd("R2", 2'd0, 3'd2, 32'd0);

        // R4: negative immediate step below the base
        wr(2'd2, 3'd4, 32'h200);
        wr(2'd3, 3'd4, 32'd8);
        wr(2'd0, 3'd4, 32'h201);
        acc("R4", 1'b1, 3'd4, 1'b1, 3'd0, 32'hFFFF_FFFD, 1'b0);
        rd("R4", 2'd0, 3'd4, 32'h206);

        // R1: premodify runs past the buffer linearly and keeps the index
        acc("R1", 1'b0, 3'd4, 1'b1, 3'd0, 32'd16, 1'b0);
        chk("R1", "linear addr", 64'(addr_out), 64'h216);
        rd("R1", 2'd0, 3'd4, 32'h206);

        // R11: idle cycle after an access
        idle("R11", 1'b0);

        // R5: zero length, plain add
        wr(2'd0, 3'd1, 32'h7000);
        acc("R5", 1'b1, 3'd1, 1'b1, 3'd0, 32'h1234, 1'b0);
        rd("R5", 2'd0, 3'd1, 32'h8234);

        // R7: same wrap on an ordinary set gives no interrupt
        wr(2'd2, 3'd3, 32'h1000);
        wr(2'd3, 3'd3, 32'h10);
        wr(2'd0, 3'd3, 32'h100C);
        acc("R7", 1'b1, 3'd3, 1'b1, 3'd0, 32'd4, 1'b0);
        chk("R7", "plain set irq", 64'(ovf_irq), 64'd0);
        // R7 / R9: wrap on the watched set
        wr(2'd2, 3'd7, 32'h1000);
        wr(2'd3, 3'd7, 32'h10);
        wr(2'd0, 3'd7, 32'h100C);
        acc("R7", 1'b1, 3'd7, 1'b1, 3'd0, 32'd4, 1'b0);
        chk("R7", "watched irq", 64'(ovf_irq), 64'd1);
        idle("R9", 1'b0);
        chk("R9", "sticky held", 64'(ovf_sticky), 64'd1);
        idle("R9", 1'b1);
        chk("R9", "sticky cleared", 64'(ovf_sticky), 64'd0);
        // R9: set and clear together, set wins
        wr(2'd0, 3'd7, 32'h100F);
        acc("R9", 1'b1, 3'd7, 1'b1, 3'd0, 32'd2, 1'b1);
        chk("R9", "set beats clear", 64'(ovf_sticky), 64'd1);
        idle("R9", 1'b1);
        // R8: zero length on the watched set still flags
        wr(2'd2, 3'd7, 32'h50);
        wr(2'd3, 3'd7, 32'd0);
        wr(2'd0, 3'd7, 32'h60);
        acc("R8", 1'b1, 3'd7, 1'b1, 3'd0, 32'd1, 1'b0);
        chk("R8", "irq with zero length", 64'(ovf_irq), 64'd1);
        rd("R8", 2'd0, 3'd7, 32'h61);
        idle("R8", 1'b1);
        // R7: premodify on the watched set never flags
        acc("R7", 1'b0, 3'd7, 1'b1, 3'd0, 32'd100, 1'b0);

        // random buffers and mixed accesses
        for (int it = 0; it < 250; it++) begin
            logic [2:0] s;
            logic [31:0] b, l, st, mag;
            s = 3'($urandom_range(0, 7));
            b = $urandom;
            l = ($urandom_range(0, 5) == 0) ? 32'd0 : 32'($urandom_range(1, 64));
            st = (l == 0) ? b + 32'($urandom_range(0, 40)) : b + 32'($urandom_range(0, int'(l) - 1));
            wr(2'd2, s, b);
            wr(2'd3, s, l);
            wr(2'd0, s, st);
            for (int q = 0; q < 6; q++) begin
                bit neg, imm, post;
                logic [2:0] ms;
                mag = (l == 0) ? 32'($urandom_range(0, 50)) : 32'($urandom_range(0, int'(l) - 1));
                neg = $urandom_range(0, 1) == 1;
                imm = $urandom_range(0, 1) == 1;
                post = $urandom_range(0, 3) != 0;
                ms = 3'($urandom_range(0, 7));
                if (!imm) wr(2'd1, ms, neg ? -mag : mag);
                acc(post ? "R2" : "R1", post, s, imm, ms, neg ? -mag : mag,
                    $urandom_range(0, 4) == 0);
            end
            rd("R10", 2'd0, s, m_idx[s]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule